// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. It holds 18-bit words, and a parameter sets the depth to 256, 512 or 1024. The writer pushes a word on any write-clock edge where its enable is high and the buffer is not full. The reader pops a word on any read-clock edge where its enable is high and the buffer is not empty. A popped word appears on the read data output after that read edge.

Five active-low level indicators describe how much data the buffer holds:
- empty
- almost-empty
- half-full
- almost-full
- full

The almost-empty and almost-full thresholds come from two 10-bit offset registers. The almost-empty offset `n` is loaded on the read clock. The almost-full offset `m` is loaded on the write clock. Reset sets both offsets to depth/8 − 1.

Each side keeps a binary pointer one bit wider than the address. It passes a Gray-coded copy of that pointer to the other clock domain through two flip-flops. The empty and full decisions are made on these delayed pointer copies, so they are conservative. Almost-full is different: it compares the two live pointers directly. It therefore falls on the write edge that reaches the threshold and rises on the read edge that leaves it.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with no loss and no duplication. `rd_data` changes only on a read-clock edge that accepts a read and holds its value otherwise.
- R2: `empty_n` is low exactly when the read side sees an occupancy of 0. A read request while `empty_n` is low does nothing: it moves no pointer and leaves `rd_data` unchanged.
- R3: `full_n` is low exactly when the write side sees an occupancy equal to the depth. A write request while `full_n` is low does nothing: the word is dropped and no stored word changes.
- R4: `aempty_n` is low while the occupancy is between 0 and `n` inclusive, and high above `n`.
- R5: `half_n` is low while the occupancy is greater than depth/2, and high at depth/2 or fewer words.
- R6: `afull_n` is low while the occupancy is at least depth − `m`. It falls on the write-clock edge that reaches that level and rises on the read-clock edge that drops below it.
- R7: Both offsets reset to depth/8 − 1, which is 31 for depth 256. `af_off_ld` loads `af_off_in` as `m` on a write-clock edge. `ae_off_ld` loads `ae_off_in` as `n` on a read-clock edge.
- R8: A low `rst_n` does all of the following:
  - clears both pointers and sets `rd_data` to 0;
  - restores the default offsets;
  - sets the flags to the empty state: `empty_n`=0, `aempty_n`=0, `half_n`=1, `afull_n`=1, `full_n`=1.
- R9: A write reaches `empty_n` and `aempty_n` within three read-clock edges. A read reaches `full_n` and `half_n` within three write-clock edges. `empty_n` is never high while the true occupancy is 0, and `full_n` is never high while the true occupancy equals the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request, sampled on wclk |
| wr_data | input | 18 | Word to store |
| rd_en | input | 1 | Read request, sampled on rclk |
| rd_data | output | 18 | Last word read |
| af_off_ld | input | 1 | Load strobe for the almost-full offset (wclk) |
| af_off_in | input | 10 | Almost-full offset value `m` |
| ae_off_ld | input | 1 | Load strobe for the almost-empty offset (rclk) |
| ae_off_in | input | 10 | Almost-empty offset value `n` |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when occupancy ≤ `n` |
| half_n | output | 1 | Low when occupancy > depth/2 |
| afull_n | output | 1 | Low when occupancy ≥ depth − `m` |
| full_n | output | 1 | Low when full |

## Verification
Three kinds of result are due on the edge that caused them:
- `full_n`, `half_n` and `afull_n` are correct right after the write edge that changed the occupancy.
- `empty_n`, `aempty_n`, `afull_n` and `rd_data` are correct right after the read edge.
- The bench samples each of these on the next falling edge of the same clock.

Flags that depend on the other domain need up to three edges of the receiving clock. Before comparing every flag with the count computed from the bench's own queue model, the bench therefore waits five falling edges of each clock. The two clock periods are chosen so that no falling edge of one clock ever coincides with a rising edge of the other.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int WORD_W     = 18;
    localparam int OFF_W      = 10;
    localparam int CMP_W      = 12;
    localparam int GRAY_MAX_W = 16;

    function automatic logic [GRAY_MAX_W-1:0] gray_to_bin(input logic [GRAY_MAX_W-1:0] g);
        logic [GRAY_MAX_W-1:0] b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic int default_offset(input int depth);
        return depth / 8 - 1;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W = ADDR_W + 1
)(
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] rd_gray_s,
    input  logic             af_off_ld,
    input  logic [OFF_W-1:0] af_off_in,
    output logic [PTR_W-1:0] w_bin,
    output logic [PTR_W-1:0] w_gray,
    output logic             w_we,
    output logic             full_n,
    output logic             half_n,
    output logic [OFF_W-1:0] af_off
);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_CNT = PTR_W'(DEPTH / 2);
    localparam logic [OFF_W-1:0] OFF_DEF  = OFF_W'(default_offset(DEPTH));

    logic [PTR_W-1:0] rd_bin_s;
    logic [PTR_W-1:0] occ_w;
    logic [PTR_W-1:0] w_bin_nxt;

    // Write-side view of occupancy: never below the true count.
    always_comb begin
        rd_bin_s  = PTR_W'(gray_to_bin(GRAY_MAX_W'(rd_gray_s)));
        occ_w     = w_bin - rd_bin_s;
        full_n    = (occ_w != FULL_CNT);
        half_n    = !(occ_w > HALF_CNT);
        w_we      = wr_en & full_n;
        w_bin_nxt = w_bin + PTR_W'(w_we);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            w_bin  <= '0;
            w_gray <= '0;
        end else begin
            w_bin  <= w_bin_nxt;
            w_gray <= w_bin_nxt ^ (w_bin_nxt >> 1);
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            af_off <= OFF_DEF;
        end else if (af_off_ld) begin
            af_off <= af_off_in;
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W = ADDR_W + 1
)(
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] wr_gray_s,
    input  logic             ae_off_ld,
    input  logic [OFF_W-1:0] ae_off_in,
    output logic [PTR_W-1:0] r_bin,
    output logic [PTR_W-1:0] r_gray,
    output logic             r_re,
    output logic             empty_n,
    output logic             aempty_n
);
    localparam logic [OFF_W-1:0] OFF_DEF = OFF_W'(default_offset(DEPTH));

    logic [PTR_W-1:0] wr_bin_s;
    logic [PTR_W-1:0] occ_r;
    logic [PTR_W-1:0] r_bin_nxt;
    logic [OFF_W-1:0] ae_off;

    // Read-side view of occupancy: never above the true count.
    always_comb begin
        wr_bin_s  = PTR_W'(gray_to_bin(GRAY_MAX_W'(wr_gray_s)));
        occ_r     = wr_bin_s - r_bin;
        empty_n   = (occ_r != '0);
        aempty_n  = (CMP_W'(occ_r) > CMP_W'(ae_off));
        r_re      = rd_en & empty_n;
        r_bin_nxt = r_bin + PTR_W'(r_re);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            r_bin  <= '0;
            r_gray <= '0;
        end else begin
            r_bin  <= r_bin_nxt;
            r_gray <= r_bin_nxt ^ (r_bin_nxt >> 1);
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            ae_off <= OFF_DEF;
        end else if (ae_off_ld) begin
            ae_off <= ae_off_in;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DEPTH = 256,
    parameter int W = 18,
    localparam int ADDR_W = $clog2(DEPTH)
)(
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W = ADDR_W + 1
)(
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              af_off_ld,
    input  logic [OFF_W-1:0]  af_off_in,
    input  logic              ae_off_ld,
    input  logic [OFF_W-1:0]  ae_off_in,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              half_n,
    output logic              afull_n,
    output logic              full_n
);
    localparam logic [CMP_W-1:0] DEPTH_C = CMP_W'(DEPTH);

    if ((1 << ADDR_W) != DEPTH || DEPTH > 1024 || DEPTH < 16) begin : g_bad_depth
        $error("dual_clock_flag_fifo: DEPTH must be a power of two from 16 to 1024");
    end

    logic [PTR_W-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PTR_W-1:0] w_gray_s, r_gray_s;
    logic             w_we, r_re;
    logic [OFF_W-1:0] af_off;
    logic [PTR_W-1:0] occ_true;
    logic [CMP_W-1:0] af_sum;

    dcf_sync #(.W(PTR_W)) u_sync_w2r (
        .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s)
    );

    dcf_sync #(.W(PTR_W)) u_sync_r2w (
        .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s)
    );

    dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rd_gray_s(r_gray_s),
        .af_off_ld(af_off_ld), .af_off_in(af_off_in),
        .w_bin(w_bin), .w_gray(w_gray), .w_we(w_we),
        .full_n(full_n), .half_n(half_n), .af_off(af_off)
    );

    dcf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .wr_gray_s(w_gray_s),
        .ae_off_ld(ae_off_ld), .ae_off_in(ae_off_in),
        .r_bin(r_bin), .r_gray(r_gray), .r_re(r_re),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcf_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
        .wclk(wclk), .we(w_we), .waddr(w_bin[ADDR_W-1:0]), .wdata(wr_data),
        .rclk(rclk), .rst_n(rst_n), .re(r_re), .raddr(r_bin[ADDR_W-1:0]),
        .rdata(rd_data)
    );

    // Almost-full compares live pointers of both domains: set by a write
    // edge, cleared by a read edge.
    always_comb begin
        occ_true = w_bin - r_bin;
        af_sum   = CMP_W'(occ_true) + CMP_W'(af_off);
        afull_n  = (af_sum < DEPTH_C);
    end
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH) + 1
)(
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             empty_n,
    input logic             aempty_n,
    input logic             full_n,
    input logic [PTR_W-1:0] w_bin,
    input logic [PTR_W-1:0] r_bin
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [PTR_W-1:0] occ;
    assign occ = w_bin - r_bin;

    a_r2_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> (r_bin == $past(r_bin)));

    a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !full_n) |=> (w_bin == $past(w_bin)));

    a_r9_empty_safe: assert property (@(posedge rclk) disable iff (!rst_n)
        empty_n |-> (occ != '0));

    a_r9_full_safe: assert property (@(posedge wclk) disable iff (!rst_n)
        full_n |-> (occ != DEPTH_P));

    a_r4_ae_implies_data: assert property (@(posedge rclk) disable iff (!rst_n)
        aempty_n |-> empty_n);

    a_r1_bounded: assert property (@(posedge wclk) disable iff (!rst_n)
        occ <= DEPTH_P);
endmodule

bind dual_clock_flag_fifo dcf_checker #(.DEPTH(DEPTH)) u_dcf_checker (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n),
    .w_bin(w_bin), .r_bin(r_bin)
);

// File: tb/dual_clock_flag_fifo_bench.sv
module dual_clock_flag_fifo_bench;
    import dcf_pkg::*;

    localparam int DEPTH = 256;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, af_off_ld = 1'b0, ae_off_ld = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] rd_data;
    logic [OFF_W-1:0] af_off_in = '0, ae_off_in = '0;
    logic empty_n, aempty_n, half_n, afull_n, full_n;

    int checks = 0;
    int errors = 0;
    int n_exp = DEPTH / 8 - 1;
    int m_exp = DEPTH / 8 - 1;
    logic [WORD_W-1:0] model [$];

    always #10 wclk = ~wclk;   // 50 MHz write clock
    always #14 rclk = ~rclk;

    dual_clock_flag_fifo #(.DEPTH(DEPTH)) u_dual_clock_flag_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .af_off_ld(af_off_ld), .af_off_in(af_off_in),
        .ae_off_ld(ae_off_ld), .ae_off_in(ae_off_in),
        .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // {empty_n, aempty_n, half_n, afull_n, full_n} for k stored words
    function automatic logic [4:0] exp_flags(input int k);
        return {k != 0, k > n_exp, !(k > DEPTH / 2), !(k >= DEPTH - m_exp), k != DEPTH};
    endfunction

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (5) @(negedge wclk);
    endtask

    task automatic check_all(input string ctx);
        logic [4:0] e;
        e = exp_flags(model.size());
        check({"R2 empty_n ", ctx}, empty_n, e[4]);
        check({"R4 aempty_n ", ctx}, aempty_n, e[3]);
        check({"R5 half_n ", ctx}, half_n, e[2]);
        check({"R6 afull_n ", ctx}, afull_n, e[1]);
        check({"R3 full_n ", ctx}, full_n, e[0]);
    endtask

    task automatic wr_word(input logic [WORD_W-1:0] d);
        logic [4:0] e;
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        if (full_n) model.push_back(d);
        @(negedge wclk);
        wr_en = 1'b0;
        e = exp_flags(model.size());
        check("R6 afull_n after write edge", afull_n, e[1]);
        check("R3 full_n after write edge", full_n, e[0]);
        check("R5 half_n after write edge", half_n, e[2]);
    endtask

    task automatic rd_word();
        logic ok;
        logic [WORD_W-1:0] exp_d, prev;
        logic [4:0] e;
        @(negedge rclk);
        ok    = empty_n;
        rd_en = 1'b1;
        prev  = rd_data;
        exp_d = '0;
        if (ok) exp_d = model.pop_front();
        @(negedge rclk);
        rd_en = 1'b0;
        if (ok) check("R1 read order", rd_data, exp_d);
        else    check("R2 read while empty keeps rd_data", rd_data, prev);
        e = exp_flags(model.size());
        check("R2 empty_n after read edge", empty_n, e[4]);
        check("R4 aempty_n after read edge", aempty_n, e[3]);
        check("R6 afull_n released on read edge", afull_n, e[1]);
    endtask

    task automatic load_af(input int v);
        @(negedge wclk);
        af_off_in = OFF_W'(v);
        af_off_ld = 1'b1;
        @(negedge wclk);
        af_off_ld = 1'b0;
        m_exp = v;
    endtask

    task automatic load_ae(input int v);
        @(negedge rclk);
        ae_off_in = OFF_W'(v);
        ae_off_ld = 1'b1;
        @(negedge rclk);
        ae_off_ld = 1'b0;
        n_exp = v;
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rd_en = 1'b0;
        @(negedge wclk);
        rst_n = 1'b0;
        repeat (3) @(negedge wclk);
        rst_n = 1'b1;
        model.delete();
        n_exp = DEPTH / 8 - 1;
        m_exp = DEPTH / 8 - 1;
        settle();
    endtask

    task automatic fill_to(input int target, input string ctx);
        while (model.size() < target) begin
            wr_word(WORD_W'(($urandom & 32'h3FFFF)));
            settle();
            check_all(ctx);
        end
    endtask

    task automatic drain_to(input int target, input string ctx);
        while (model.size() > target) begin
            rd_word();
            settle();
            check_all(ctx);
        end
    endtask

    initial begin : watchdog
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete (R9 progress), actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd424242));
        do_reset();

        // R8: reset state of flags and read data
        check("R8 empty_n at reset", empty_n, 1'b0);
        check("R8 aempty_n at reset", aempty_n, 1'b0);
        check("R8 half_n at reset", half_n, 1'b1);
        check("R8 afull_n at reset", afull_n, 1'b1);
        check("R8 full_n at reset", full_n, 1'b1);
        check("R8 rd_data at reset", rd_data, '0);

        // R2: reading an empty buffer has no effect
        rd_word();
        settle();
        check_all("R2 after empty read");

        // Default offsets (R7): walk up through every band, then overfill
        fill_to(DEPTH, "R9 fill default offsets");
        wr_word(18'h2AAAA);
        settle();
        check_all("R3 write while full dropped");
        drain_to(0, "R9 drain default offsets");
        rd_word();
        check("R3 dropped word never appears", model.size(), 0);

        // R7: programmed offsets n=5, m=10
        load_af(10);
        load_ae(5);
        settle();
        check_all("R7 programmed at zero");
        fill_to(DEPTH, "R7 programmed fill");
        drain_to(0, "R7 programmed drain");

        // R8: reset with data held, then defaults back in force
        fill_to(40, "R7 before reset");
        do_reset();
        check_all("R8 after mid reset");
        rd_word();
        fill_to(33, "R7 defaults reloaded");
        drain_to(0, "R7 defaults drain");

        // R1: constrained random traffic on both clocks
        fork
            begin : wr_proc
                for (int i = 0; i < 3000; i++) begin
                    int wp;
                    wp = ((i / 500) % 2 == 1) ? 85 : 30;
                    @(negedge wclk);
                    wr_en   = (($urandom % 100) < wp);
                    wr_data = WORD_W'($urandom & 32'h3FFFF);
                    if (wr_en && full_n) model.push_back(wr_data);
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin : rd_proc
                logic pend;
                logic [WORD_W-1:0] exp_d;
                pend = 1'b0;
                exp_d = '0;
                for (int i = 0; i < 2200; i++) begin
                    int rp;
                    rp = ((i / 400) % 2 == 1) ? 25 : 80;
                    @(negedge rclk);
                    if (pend) check("R1 random read data", rd_data, exp_d);
                    rd_en = (($urandom % 100) < rp);
                    pend  = rd_en && empty_n;
                    if (pend) exp_d = model.pop_front();
                end
                @(negedge rclk);
                if (pend) check("R1 random read data", rd_data, exp_d);
                rd_en = 1'b0;
            end
        join
        settle();
        check_all("R9 after random traffic");
        drain_to(0, "R1 final drain");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule